// File: doc/BRIEF.md
# Accumulator Adder and Logic Unit

This block holds a 16-bit accumulator together with a one-bit extend flag, and computes the value that is loaded into them on each clock. The accumulator draws its operand from a 16-bit data word, and it can also take in an 8-bit character. A surrounding sequencer drives a set of operation strobes, normally one at a time. The block performs the selected operation at the next rising clock edge. If no strobe is active, both registers keep their contents.

The extend flag has two roles. It catches the carry out of an addition, and it acts as the extra bit that a rotate passes through during left and right shifts. The flag can also be cleared or inverted on its own. The character input overwrites only the low byte of the accumulator. Clear and increment act on the accumulator register directly and do not pass through the adder.

Top module: `acc_alu`

## Requirements
- R1: While rstN is low, acOut reads 0 and eOut reads 0.
- R2: The and strobe loads acOut with acOut AND drIn. eOut does not change.
- R3: The add strobe loads {eOut, acOut} with the 17-bit sum acOut + drIn. eOut takes the carry out of bit 15.
- R4: The load strobe copies drIn into acOut. eOut does not change.
- R5: The input strobe writes inpIn into acOut[7:0]. acOut[15:8] and eOut do not change.
- R6: The complement strobe inverts every bit of acOut. eOut does not change.
- R7: The shift-right strobe writes {eOut, acOut[15:1]} into acOut and acOut[0] into eOut.
- R8: The shift-left strobe writes {acOut[14:0], eOut} into acOut and acOut[15] into eOut.
- R9: The clear strobe sets acOut to 0. eOut does not change.
- R10: The increment strobe adds 1 to acOut modulo 2^16, so 0xFFFF becomes 0x0000. eOut does not change.
- R11: The flag-clear strobe sets eOut to 0, and the flag-invert strobe inverts eOut. Neither strobe changes acOut.
- R12: While no strobe is active, acOut and eOut hold their values whatever drIn and inpIn carry.
- R13: If several strobes are active at once, only one takes effect. The order of precedence, highest first, is: clear, increment, and, add, load, input, complement, shift right, shift left, flag clear, flag invert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| drIn | input | 16 | Data-word operand |
| inpIn | input | 8 | Input character |
| opClr | input | 1 | Clear the accumulator |
| opInc | input | 1 | Increment the accumulator |
| opAnd | input | 1 | AND drIn into the accumulator |
| opAdd | input | 1 | Add drIn, with the carry going to the flag |
| opLdr | input | 1 | Load drIn |
| opInp | input | 1 | Load the character into the low byte |
| opCma | input | 1 | Complement the accumulator |
| opShr | input | 1 | Shift right through the flag |
| opShl | input | 1 | Shift left through the flag |
| opCle | input | 1 | Clear the flag |
| opCme | input | 1 | Invert the flag |
| acOut | output | 16 | Accumulator value |
| eOut | output | 1 | Extend flag value |

## Verification
The bench builds the block with its default widths: a 16-bit accumulator and an 8-bit character. With these widths, a carry out of bit 15 can be produced and checked. They also leave an upper byte that the character load must preserve. Directed sequences cover the following cases:
- an addition that produces a carry, and one that does not;
- two chained right rotates followed by a left rotate, which carry the flag in and out of each end;
- an increment that wraps from 0xFFFF;
- pairs of strobes raised together, to confirm the order of precedence.

// File: rtl/acc_pkg.sv
package acc_pkg;
  typedef enum logic [2:0] {
    ALU_AND, ALU_ADD, ALU_DR, ALU_INP, ALU_CMA, ALU_SHR, ALU_SHL
  } alu_sel_e;

  typedef struct packed {
    logic     acLd;
    logic     acInc;
    logic     acClr;
    logic     eLd;
    logic     eClr;
    logic     eCmp;
    alu_sel_e aluSel;
  } acc_ctrl_t;
endpackage

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
(
  input  logic      opClr,
  input  logic      opInc,
  input  logic      opAnd,
  input  logic      opAdd,
  input  logic      opLdr,
  input  logic      opInp,
  input  logic      opCma,
  input  logic      opShr,
  input  logic      opShl,
  input  logic      opCle,
  input  logic      opCme,
  output acc_ctrl_t ctrl
);
  always_comb begin
    ctrl = '{acLd: 1'b0, acInc: 1'b0, acClr: 1'b0, eLd: 1'b0,
             eClr: 1'b0, eCmp: 1'b0, aluSel: ALU_DR};
    if (opClr) begin
      ctrl.acClr = 1'b1;
    end else if (opInc) begin
      ctrl.acInc = 1'b1;
    end else if (opAnd) begin
      ctrl.acLd = 1'b1; ctrl.aluSel = ALU_AND;
    end else if (opAdd) begin
      ctrl.acLd = 1'b1; ctrl.eLd = 1'b1; ctrl.aluSel = ALU_ADD;
    end else if (opLdr) begin
      ctrl.acLd = 1'b1; ctrl.aluSel = ALU_DR;
    end else if (opInp) begin
      ctrl.acLd = 1'b1; ctrl.aluSel = ALU_INP;
    end else if (opCma) begin
      ctrl.acLd = 1'b1; ctrl.aluSel = ALU_CMA;
    end else if (opShr) begin
      ctrl.acLd = 1'b1; ctrl.eLd = 1'b1; ctrl.aluSel = ALU_SHR;
    end else if (opShl) begin
      ctrl.acLd = 1'b1; ctrl.eLd = 1'b1; ctrl.aluSel = ALU_SHL;
    end else if (opCle) begin
      ctrl.eClr = 1'b1;
    end else if (opCme) begin
      ctrl.eCmp = 1'b1;
    end
  end
endmodule

// File: rtl/acc_logic.sv
module acc_logic
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8
) (
  input  alu_sel_e          sel,
  input  logic [DATA_W-1:0] acCur,
  input  logic              eCur,
  input  logic [DATA_W-1:0] drIn,
  input  logic [CHAR_W-1:0] inpIn,
  output logic [DATA_W-1:0] acNext,
  output logic              eNext
);
  logic [DATA_W:0]   sumWide;
  logic [DATA_W-1:0] inpMerged;

  assign sumWide = {1'b0, acCur} + {1'b0, drIn};

  generate
    if (CHAR_W < DATA_W) begin : gMerge
      assign inpMerged = {acCur[DATA_W-1:CHAR_W], inpIn};
    end else begin : gFull
      assign inpMerged = inpIn[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    acNext = acCur;
    eNext  = eCur;
    case (sel)
      ALU_AND: acNext = acCur & drIn;
      ALU_ADD: {eNext, acNext} = sumWide;
      ALU_DR:  acNext = drIn;
      ALU_INP: acNext = inpMerged;
      ALU_CMA: acNext = ~acCur;
      ALU_SHR: begin
        acNext = {eCur, acCur[DATA_W-1:1]};
        eNext  = acCur[0];
      end
      ALU_SHL: begin
        acNext = {acCur[DATA_W-2:0], eCur};
        eNext  = acCur[DATA_W-1];
      end
      default: acNext = acCur;
    endcase
  end
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  acc_ctrl_t         ctrl,
  input  logic [DATA_W-1:0] drIn,
  input  logic [CHAR_W-1:0] inpIn,
  output logic [DATA_W-1:0] acOut,
  output logic              eOut
);
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] acReg;
  logic              eReg;
  logic [DATA_W-1:0] aluAc;
  logic              aluE;

  acc_logic #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) uLogic (
    .sel(ctrl.aluSel), .acCur(acReg), .eCur(eReg),
    .drIn(drIn), .inpIn(inpIn), .acNext(aluAc), .eNext(aluE)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            acReg <= '0;
    else if (ctrl.acClr)  acReg <= '0;
    else if (ctrl.acInc)  acReg <= acReg + ONE;
    else if (ctrl.acLd)   acReg <= aluAc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           eReg <= 1'b0;
    else if (ctrl.eClr)  eReg <= 1'b0;
    else if (ctrl.eCmp)  eReg <= ~eReg;
    else if (ctrl.eLd)   eReg <= aluE;
  end

  assign acOut = acReg;
  assign eOut  = eReg;
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] drIn,
  input  logic [CHAR_W-1:0] inpIn,
  input  logic              opClr,
  input  logic              opInc,
  input  logic              opAnd,
  input  logic              opAdd,
  input  logic              opLdr,
  input  logic              opInp,
  input  logic              opCma,
  input  logic              opShr,
  input  logic              opShl,
  input  logic              opCle,
  input  logic              opCme,
  output logic [DATA_W-1:0] acOut,
  output logic              eOut
);
  acc_ctrl_t ctrl;

  acc_ctrl uCtrl (
    .opClr(opClr), .opInc(opInc), .opAnd(opAnd), .opAdd(opAdd),
    .opLdr(opLdr), .opInp(opInp), .opCma(opCma), .opShr(opShr),
    .opShl(opShl), .opCle(opCle), .opCme(opCme), .ctrl(ctrl)
  );

  acc_datapath #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .drIn(drIn), .inpIn(inpIn),
    .acOut(acOut), .eOut(eOut)
  );
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] drIn,
  input logic [CHAR_W-1:0] inpIn,
  input logic              opClr,
  input logic              opInc,
  input logic              opAnd,
  input logic              opAdd,
  input logic              opLdr,
  input logic              opInp,
  input logic              opCma,
  input logic              opShr,
  input logic              opShl,
  input logic              opCle,
  input logic              opCme,
  input logic [DATA_W-1:0] acOut,
  input logic              eOut
);
  logic [10:0] ops;
  logic        single;
  assign ops = {opCme, opCle, opShl, opShr, opCma, opInp, opLdr, opAdd, opAnd, opInc, opClr};
  assign single = ($countones(ops) == 1);

  AST_RESET_ZERO: assert property (@(posedge clk) !rstN |-> (acOut == '0 && !eOut)); // R1
  AST_AND_OP: assert property (@(posedge clk) disable iff (!rstN)
    (opAnd && single) |=> (acOut == ($past(acOut) & $past(drIn)) && $stable(eOut))); // R2
  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (opAdd && single) |=> ({eOut, acOut} == ({1'b0, $past(acOut)} + {1'b0, $past(drIn)}))); // R3
  AST_LOAD_DR: assert property (@(posedge clk) disable iff (!rstN)
    (opLdr && single) |=> (acOut == $past(drIn) && $stable(eOut))); // R4
  AST_INP_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (opInp && single) |=> (acOut[CHAR_W-1:0] == $past(inpIn) &&
      acOut[DATA_W-1:CHAR_W] == $past(acOut[DATA_W-1:CHAR_W]) && $stable(eOut))); // R5
  AST_CMA_INV: assert property (@(posedge clk) disable iff (!rstN)
    (opCma && single) |=> (acOut == ~$past(acOut) && $stable(eOut))); // R6
  AST_SHR_ROT: assert property (@(posedge clk) disable iff (!rstN)
    (opShr && single) |=> ({acOut, eOut} == {$past(eOut), $past(acOut)})); // R7
  AST_SHL_ROT: assert property (@(posedge clk) disable iff (!rstN)
    (opShl && single) |=> ({eOut, acOut} == {$past(acOut), $past(eOut)})); // R8
  AST_CLR_AC: assert property (@(posedge clk) disable iff (!rstN)
    (opClr && single) |=> (acOut == '0 && $stable(eOut))); // R9
  AST_INC_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (opInc && single) |=> (acOut == $past(acOut) + 1'b1 && $stable(eOut))); // R10
  AST_CLE_OP: assert property (@(posedge clk) disable iff (!rstN)
    (opCle && single) |=> (!eOut && $stable(acOut))); // R11
  AST_CME_OP: assert property (@(posedge clk) disable iff (!rstN)
    (opCme && single) |=> (eOut == !$past(eOut) && $stable(acOut))); // R11
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ops == '0) |=> ($stable(acOut) && $stable(eOut))); // R12
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    opClr |=> (acOut == '0 && $stable(eOut))); // R13
endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) uChk (
  .clk(clk), .rstN(rstN), .drIn(drIn), .inpIn(inpIn),
  .opClr(opClr), .opInc(opInc), .opAnd(opAnd), .opAdd(opAdd),
  .opLdr(opLdr), .opInp(opInp), .opCma(opCma), .opShr(opShr),
  .opShl(opShl), .opCle(opCle), .opCme(opCme), .acOut(acOut), .eOut(eOut)
);

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 16;
  localparam int CHAR_W = 8;
  // strobe indices
  localparam int I_CLR = 0, I_INC = 1, I_AND = 2, I_ADD = 3, I_LDR = 4, I_INP = 5;
  localparam int I_CMA = 6, I_SHR = 7, I_SHL = 8, I_CLE = 9, I_CME = 10;

  logic clk = 1'b0;
  logic rstN;
  logic [DATA_W-1:0] drIn;
  logic [CHAR_W-1:0] inpIn;
  logic [10:0] opVec;
  logic [DATA_W-1:0] acOut;
  logic eOut;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_alu #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) dut (
    .clk(clk), .rstN(rstN), .drIn(drIn), .inpIn(inpIn),
    .opClr(opVec[I_CLR]), .opInc(opVec[I_INC]), .opAnd(opVec[I_AND]),
    .opAdd(opVec[I_ADD]), .opLdr(opVec[I_LDR]), .opInp(opVec[I_INP]),
    .opCma(opVec[I_CMA]), .opShr(opVec[I_SHR]), .opShl(opVec[I_SHL]),
    .opCle(opVec[I_CLE]), .opCme(opVec[I_CME]), .acOut(acOut), .eOut(eOut)
  );

  task automatic check(string tag, logic [DATA_W:0] act, logic [DATA_W:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {e,ac} actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive strobes at a negedge, sample at the following negedge.
  task automatic run(logic [10:0] ops, logic [DATA_W-1:0] dr, logic [CHAR_W-1:0] inp);
    opVec = ops; drIn = dr; inpIn = inp;
    @(negedge clk);
    opVec = '0;
  endtask

  function automatic logic [10:0] bitOf(int i);
    return 11'(1) << i;
  endfunction

  task automatic testReset();
    check("R1 reset", {eOut, acOut}, 17'h0);
  endtask

  task automatic testLoadAnd();
    run(bitOf(I_LDR), 16'h1234, 8'h00);
    check("R4 load", {eOut, acOut}, {1'b0, 16'h1234});
    run(bitOf(I_AND), 16'h0F0F, 8'h00);
    check("R2 and", {eOut, acOut}, {1'b0, 16'h0204});
  endtask

  task automatic testAdd();
    run(bitOf(I_ADD), 16'hFFFF, 8'h00);
    check("R3 add with carry", {eOut, acOut}, {1'b1, 16'h0203});
    run(bitOf(I_LDR), 16'h00FF, 8'h00);
    check("R4 load keeps e", {eOut, acOut}, {1'b1, 16'h00FF});
    run(bitOf(I_ADD), 16'h0001, 8'h00);
    check("R3 add no carry", {eOut, acOut}, {1'b0, 16'h0100});
  endtask

  task automatic testInpCma();
    run(bitOf(I_CME), 16'h0000, 8'h00);
    check("R11 invert flag", {eOut, acOut}, {1'b1, 16'h0100});
    run(bitOf(I_LDR), 16'hABCD, 8'h00);
    run(bitOf(I_INP), 16'h0000, 8'h5A);
    check("R5 input low byte", {eOut, acOut}, {1'b1, 16'hAB5A});
    run(bitOf(I_CMA), 16'h0000, 8'h00);
    check("R6 complement", {eOut, acOut}, {1'b1, 16'h54A5});
  endtask

  task automatic testShifts();
    run(bitOf(I_LDR), 16'h8001, 8'h00);
    run(bitOf(I_SHR), 16'h0000, 8'h00);
    check("R7 shift right 1", {eOut, acOut}, {1'b1, 16'hC000});
    run(bitOf(I_SHR), 16'h0000, 8'h00);
    check("R7 shift right 2", {eOut, acOut}, {1'b0, 16'hE000});
    run(bitOf(I_SHL), 16'h0000, 8'h00);
    check("R8 shift left", {eOut, acOut}, {1'b1, 16'hC000});
    run(bitOf(I_CLE), 16'h0000, 8'h00);
    check("R11 clear flag", {eOut, acOut}, {1'b0, 16'hC000});
    run(bitOf(I_CME), 16'h0000, 8'h00);
    check("R11 invert flag again", {eOut, acOut}, {1'b1, 16'hC000});
  endtask

  task automatic testClrInc();
    run(bitOf(I_CLR), 16'h0000, 8'h00);
    check("R9 clear", {eOut, acOut}, {1'b1, 16'h0000});
    run(bitOf(I_LDR), 16'hFFFF, 8'h00);
    run(bitOf(I_INC), 16'h0000, 8'h00);
    check("R10 increment wrap", {eOut, acOut}, {1'b1, 16'h0000});
    run(bitOf(I_INC), 16'h0000, 8'h00);
    check("R10 increment", {eOut, acOut}, {1'b1, 16'h0001});
  endtask

  task automatic testIdle();
    for (int k = 0; k < 3; k++) begin
      run('0, 16'hBEEF + 16'(k), 8'hC3);
      check("R12 idle hold", {eOut, acOut}, {1'b1, 16'h0001});
    end
  endtask

  task automatic testPriority();
    run(bitOf(I_INC) | bitOf(I_LDR), 16'h7777, 8'h00);
    check("R13 increment over load", {eOut, acOut}, {1'b1, 16'h0002});
    run(bitOf(I_CLR) | bitOf(I_ADD), 16'hFFFF, 8'h00);
    check("R13 clear over add", {eOut, acOut}, {1'b1, 16'h0000});
    run(bitOf(I_LDR), 16'h00F0, 8'h00);
    run(bitOf(I_AND) | bitOf(I_CMA), 16'h0030, 8'h00);
    check("R13 and over complement", {eOut, acOut}, {1'b1, 16'h0030});
    run(bitOf(I_SHL) | bitOf(I_CLE), 16'h0000, 8'h00);
    check("R13 shift over flag clear", {eOut, acOut}, {1'b0, 16'h0061});
  endtask

  initial begin
    rstN = 1'b0; opVec = '0; drIn = '0; inpIn = '0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testLoadAnd();
    testAdd();
    testInpCma();
    testShifts();
    testClrInc();
    testIdle();
    testPriority();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule